// File: doc/BRIEF.md
# Seven-Stage Alternate-Cycle Instruction Issue Controller

This block sequences 16-bit instructions through a seven-stage pipeline (two fetch, two decode, two execute, one write-back) and drives the control strobes of a bit-serial datapath. It does not hold the datapath or the memories. It puts a fetch address out and takes the instruction word back in the same fast-clock cycle. It then tells the register file, the ALU, the data memory and the write-back port what to do as each instruction passes the stage that owns that resource.

The block runs from one fast clock that stands for the local bit clock. A divider makes a system-cycle tick every `SYS_DIV` fast cycles, and the pipeline moves one stage per tick. A new instruction may enter only on every second tick, so two instructions never sit in adjacent stages. Within a system cycle, `bit_idx` counts the bit slots. `bit_win` marks, for each occupied stage, the slots in which that stage shifts its serial word. The word is instruction-wide in the fetch and decode stages and data-wide in the execute and write-back stages.

Branches and jumps resolve in the second execute stage, where the datapath reports through `br_zero` whether the tested register is zero. A halt word stops issue at once. The older instructions then drain, and the block reports that it has halted.

Top module: `serial_issue_ctrl`

## Requirements
- R1: Synchronous active-high reset sets the fetch address to 0 and empties every stage. After reset, `bit_win`, all strobes and `halted` are 0, and the first fetch, from address 0, comes on the first tick.
- R2: `fetch_en` is high only in a cycle where `sys_tick` is high. Two successive ticks never both issue, and the first tick after reset issues.
- R3: An instruction issued on a tick occupies stage k (0 = first fetch … 6 = write-back) during the k-th system cycle after that tick. A stage's occupancy is visible through `bit_win[k]` in slot 0.
- R4: Opcode is word[15:13]. Opcode 1 is a register-register operation: function [12:10], destination [9:8], source X [7:6], source Y [5:4]. In the second decode stage it gives `rd_en` with `rd_sel_x`/`rd_sel_y` = X/Y. In the first execute stage it gives `alu_en` with `alu_op` = function (0 add, 1 sub, 2 and, 3 or, 4 xor, 5 pass X, 6 pass Y). In write-back it gives `wb_en` with `wb_sel` = destination. Function 7 produces no strobes.
- R5: Opcode 2 (load, destination [9:8], address [7:0]) raises `mem_rd` with `mem_addr` in the second execute stage, then `wb_en`/`wb_sel` in write-back. Opcode 3 (store, source [9:8]) raises `rd_en` with `rd_sel_x` = source in the second decode stage, then `mem_wr` with `mem_addr`. `mem_rd` and `mem_wr` are never high together. Selects and addresses read 0 when their strobe is low.
- R6: Opcodes 4 (taken when `br_zero`=1) and 5 (taken when `br_zero`=0) read register [9:8] in the second decode stage. When taken in the second execute stage, they raise `redirect` and empty stages 0–4 on that tick, and the next fetch comes from [7:0].
- R7: Opcode 6 always redirects to [7:0] in the second execute stage.
- R8: Opcode 0 produces no strobes. Opcode 7 halts: no fetch follows it, older instructions complete, and `halted` rises on the tick after the halt word sits in write-back. `halted` then stays high until reset.
- R9: A halt word emptied by an older taken branch or jump cancels the stop, and fetching resumes at the target.
- R10: `bit_idx` counts 0 to `SYS_DIV`-1 and `sys_tick` is high in the last slot. `bit_win[k]` is high while stage k is occupied and `bit_idx` < `INSTR_BITS` (stages 0–3) or < `DATA_BITS` (stages 4–6).
- R11: Each issue advances the fetch address by one, modulo 256 (address 255 is followed by 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (local bit rate) |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | output | 1 | Instruction word is taken this cycle |
| imem_addr | output | 8 | Fetch address (program counter) |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| rd_en | output | 1 | Register-file read in the second decode stage |
| rd_sel_x | output | 2 | Read select for operand X |
| rd_sel_y | output | 2 | Read select for operand Y |
| alu_en | output | 1 | ALU operation in the first execute stage |
| alu_op | output | 3 | ALU function code |
| mem_rd | output | 1 | Data-memory read in the second execute stage |
| mem_wr | output | 1 | Data-memory write in the second execute stage |
| mem_addr | output | 8 | Data-memory address |
| br_zero | input | 1 | Tested register is zero (held over the second execute stage) |
| redirect | output | 1 | Branch or jump taken in the second execute stage |
| wb_en | output | 1 | Register write-back |
| wb_sel | output | 2 | Write-back destination |
| sys_tick | output | 1 | Last bit slot of a system cycle; pipeline advances |
| bit_idx | output | $clog2(SYS_DIV) | Bit slot within the system cycle |
| bit_win | output | 7 | Per-stage serial bit window |
| halted | output | 1 | Halt has drained through write-back |

## Verification
Branch resolution and halt can meet within one window. A taken branch in the second execute stage must empty the stage that holds a halt fetched two system cycles later, and it must also lift the stop that halt set. The program places a halt right behind a taken zero-test branch. The cycle model then expects fetching to resume at the target on the next issue slot, with `halted` still low. A later halt, one that no redirect cancels, is expected to stop fetching and raise `halted` exactly one tick after it reaches write-back.

// File: rtl/serial_issue_pkg.sv
package serial_issue_pkg;

  localparam int IW     = 16;
  localparam int NSTG   = 7;
  localparam int ST_IF0 = 0;
  localparam int ST_IF1 = 1;
  localparam int ST_ID0 = 2;
  localparam int ST_ID1 = 3;
  localparam int ST_EX0 = 4;
  localparam int ST_EX1 = 5;
  localparam int ST_WB  = 6;
  localparam int LATE_N = NSTG - ST_ID1;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ALU   = 3'd1,
    OP_LOAD  = 3'd2,
    OP_STORE = 3'd3,
    OP_BRZ   = 3'd4,
    OP_BRNZ  = 3'd5,
    OP_JUMP  = 3'd6,
    OP_HALT  = 3'd7
  } opcode_e;

  typedef struct packed {
    logic          vld;
    logic [IW-1:0] word;
  } slot_t;

  function automatic opcode_e op_of(input logic [IW-1:0] w);
    return opcode_e'(w[15:13]);
  endfunction

  function automatic logic [2:0] func_of(input logic [IW-1:0] w);
    return w[12:10];
  endfunction

  function automatic logic [1:0] dst_of(input logic [IW-1:0] w);
    return w[9:8];
  endfunction

  function automatic logic [1:0] srcx_of(input logic [IW-1:0] w);
    return w[7:6];
  endfunction

  function automatic logic [1:0] srcy_of(input logic [IW-1:0] w);
    return w[5:4];
  endfunction

  function automatic logic [7:0] imm_of(input logic [IW-1:0] w);
    return w[7:0];
  endfunction

  // register-register word with a defined ALU function
  function automatic logic alu_legal(input logic [IW-1:0] w);
    return (op_of(w) == OP_ALU) && (func_of(w) != 3'd7);
  endfunction

  function automatic logic reads_reg(input logic [IW-1:0] w);
    opcode_e o;
    o = op_of(w);
    return alu_legal(w) || (o == OP_STORE) || (o == OP_BRZ) || (o == OP_BRNZ);
  endfunction

  function automatic logic writes_reg(input logic [IW-1:0] w);
    return alu_legal(w) || (op_of(w) == OP_LOAD);
  endfunction

  function automatic logic redirects(input logic [IW-1:0] w, input logic zero);
    opcode_e o;
    o = op_of(w);
    return (o == OP_JUMP) || ((o == OP_BRZ) && zero) || ((o == OP_BRNZ) && !zero);
  endfunction

endpackage

// File: rtl/sic_tick_gen.sv
module sic_tick_gen #(
  parameter int SYS_DIV = 16,
  localparam int IDX_W = $clog2(SYS_DIV)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             tick,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SYS_DIV - 1);

  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign idx  = cnt_q;
  assign tick = (cnt_q == LAST);

endmodule

// File: rtl/sic_fetch_unit.sv
module sic_fetch_unit
  import serial_issue_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          taken,
  input  logic [7:0]    target,
  input  logic [IW-1:0] imem_data,
  input  logic          wb_halt,
  output logic          issue,
  output logic [7:0]    pc,
  output logic          halted,
  output slot_t         new_slot
);

  logic       phase_q;   // 0: this tick is an issue slot
  logic       stop_q;    // halt fetched, issue suspended
  logic       halted_q;
  logic [7:0] pc_q;
  logic       fetch_halt;

  assign issue      = tick && !phase_q && !stop_q && !taken;
  assign fetch_halt = op_of(imem_data) == OP_HALT;
  assign new_slot   = '{vld: issue, word: imem_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= 1'b0;
      stop_q   <= 1'b0;
      halted_q <= 1'b0;
      pc_q     <= '0;
    end else if (tick) begin
      phase_q <= !phase_q;
      if (wb_halt) halted_q <= 1'b1;
      if (taken) begin
        pc_q   <= target;
        stop_q <= 1'b0;
      end else if (issue) begin
        pc_q <= pc_q + 8'd1;
        if (fetch_halt) stop_q <= 1'b1;
      end
    end
  end

  assign pc     = pc_q;
  assign halted = halted_q;

endmodule

// File: rtl/sic_stage_pipe.sv
module sic_stage_pipe
  import serial_issue_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick,
  input  logic                      flush,
  input  slot_t                     head,
  output logic [NSTG-1:0]           vld,
  output logic [LATE_N-1:0][IW-1:0] late_word
);

  genvar s;
  generate
    for (s = 0; s < NSTG; s++) begin : g_stg
      slot_t q_r;
      slot_t nxt;
      if (s == 0) begin : g_head
        assign nxt = head;
      end else if (s < ST_WB) begin : g_flushable
        assign nxt = flush ? '0 : g_stg[s-1].q_r;
      end else begin : g_last
        assign nxt = g_stg[s-1].q_r;
      end

      always_ff @(posedge clk) begin
        if (rst)       q_r <= '0;
        else if (tick) q_r <= nxt;
      end

      assign vld[s] = q_r.vld;
      if (s >= ST_ID1) begin : g_out
        assign late_word[s-ST_ID1] = q_r.word;
      end
    end
  endgenerate

endmodule

// File: rtl/sic_stage_ctrl.sv
module sic_stage_ctrl
  import serial_issue_pkg::*;
#(
  parameter int INSTR_BITS = 16,
  parameter int DATA_BITS  = 8,
  parameter int IDX_W      = 4
) (
  input  logic [NSTG-1:0]           vld,
  input  logic [LATE_N-1:0][IW-1:0] late_word,
  input  logic [IDX_W-1:0]          bit_idx,
  input  logic                      br_zero,
  output logic                      rd_en,
  output logic [1:0]                rd_sel_x,
  output logic [1:0]                rd_sel_y,
  output logic                      alu_en,
  output logic [2:0]                alu_op,
  output logic                      mem_rd,
  output logic                      mem_wr,
  output logic [7:0]                mem_addr,
  output logic                      taken,
  output logic [7:0]                target,
  output logic                      wb_en,
  output logic [1:0]                wb_sel,
  output logic                      wb_halt,
  output logic [NSTG-1:0]           bit_win
);

  logic [IW-1:0] w_id1, w_ex0, w_ex1, w_wb;
  logic          id1_alu;

  assign w_id1 = late_word[ST_ID1-ST_ID1];
  assign w_ex0 = late_word[ST_EX0-ST_ID1];
  assign w_ex1 = late_word[ST_EX1-ST_ID1];
  assign w_wb  = late_word[ST_WB-ST_ID1];

  // second decode stage: register file read
  assign rd_en    = vld[ST_ID1] && reads_reg(w_id1);
  assign id1_alu  = alu_legal(w_id1);
  assign rd_sel_x = !rd_en ? 2'd0 : (id1_alu ? srcx_of(w_id1) : dst_of(w_id1));
  assign rd_sel_y = (rd_en && id1_alu) ? srcy_of(w_id1) : 2'd0;

  // first execute stage: ALU
  assign alu_en = vld[ST_EX0] && alu_legal(w_ex0);
  assign alu_op = alu_en ? func_of(w_ex0) : 3'd0;

  // second execute stage: memory and control transfer
  assign mem_rd   = vld[ST_EX1] && (op_of(w_ex1) == OP_LOAD);
  assign mem_wr   = vld[ST_EX1] && (op_of(w_ex1) == OP_STORE);
  assign mem_addr = (mem_rd || mem_wr) ? imm_of(w_ex1) : 8'd0;
  assign taken    = vld[ST_EX1] && redirects(w_ex1, br_zero);
  assign target   = imm_of(w_ex1);

  // write-back
  assign wb_en   = vld[ST_WB] && writes_reg(w_wb);
  assign wb_sel  = wb_en ? dst_of(w_wb) : 2'd0;
  assign wb_halt = vld[ST_WB] && (op_of(w_wb) == OP_HALT);

  genvar s;
  generate
    for (s = 0; s < NSTG; s++) begin : g_win
      localparam int WIN = (s <= ST_ID1) ? INSTR_BITS : DATA_BITS;
      assign bit_win[s] = vld[s] && (int'(bit_idx) < WIN);
    end
  endgenerate

endmodule

// File: rtl/serial_issue_ctrl.sv
module serial_issue_ctrl
  import serial_issue_pkg::*;
#(
  parameter int SYS_DIV    = 16,
  parameter int INSTR_BITS = 16,
  parameter int DATA_BITS  = 8,
  localparam int IDX_W = $clog2(SYS_DIV)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             fetch_en,
  output logic [7:0]       imem_addr,
  input  logic [15:0]      imem_data,
  output logic             rd_en,
  output logic [1:0]       rd_sel_x,
  output logic [1:0]       rd_sel_y,
  output logic             alu_en,
  output logic [2:0]       alu_op,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [7:0]       mem_addr,
  input  logic             br_zero,
  output logic             redirect,
  output logic             wb_en,
  output logic [1:0]       wb_sel,
  output logic             sys_tick,
  output logic [IDX_W-1:0] bit_idx,
  output logic [6:0]       bit_win,
  output logic             halted
);

  // named internal events
  logic                      tick;
  logic                      issue;
  logic                      taken;
  logic [7:0]                target;
  logic                      wb_halt;
  slot_t                     head;
  logic [NSTG-1:0]           stage_vld;
  logic [LATE_N-1:0][IW-1:0] late_word;

  sic_tick_gen #(.SYS_DIV(SYS_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .idx (bit_idx)
  );

  sic_fetch_unit u_fetch (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .taken    (taken),
    .target   (target),
    .imem_data(imem_data),
    .wb_halt  (wb_halt),
    .issue    (issue),
    .pc       (imem_addr),
    .halted   (halted),
    .new_slot (head)
  );

  sic_stage_pipe u_pipe (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .flush    (taken),
    .head     (head),
    .vld      (stage_vld),
    .late_word(late_word)
  );

  sic_stage_ctrl #(
    .INSTR_BITS(INSTR_BITS),
    .DATA_BITS (DATA_BITS),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .vld      (stage_vld),
    .late_word(late_word),
    .bit_idx  (bit_idx),
    .br_zero  (br_zero),
    .rd_en    (rd_en),
    .rd_sel_x (rd_sel_x),
    .rd_sel_y (rd_sel_y),
    .alu_en   (alu_en),
    .alu_op   (alu_op),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .taken    (taken),
    .target   (target),
    .wb_en    (wb_en),
    .wb_sel   (wb_sel),
    .wb_halt  (wb_halt),
    .bit_win  (bit_win)
  );

  assign fetch_en = issue;
  assign redirect = taken;
  assign sys_tick = tick;

endmodule

// File: rtl/serial_issue_ctrl_sva.sv
module serial_issue_ctrl_sva (
  input logic       clk,
  input logic       rst,
  input logic       fetch_en,
  input logic       sys_tick,
  input logic [7:0] imem_addr,
  input logic       redirect,
  input logic       halted,
  input logic [6:0] bit_win,
  input logic       mem_rd,
  input logic       mem_wr
);

  logic prev_issue;

  always_ff @(posedge clk) begin
    if (rst)           prev_issue <= 1'b0;
    else if (sys_tick) prev_issue <= fetch_en;
  end

  a_r2_fetch_on_tick: assert property (@(posedge clk) disable iff (rst)
    fetch_en |-> sys_tick);

  a_r2_no_adjacent_issue: assert property (@(posedge clk) disable iff (rst)
    (sys_tick && fetch_en) |-> !prev_issue);

  a_r11_pc_step: assert property (@(posedge clk) disable iff (rst)
    fetch_en |=> (imem_addr == $past(imem_addr) + 8'd1));

  a_r6_flush_younger: assert property (@(posedge clk) disable iff (rst)
    (sys_tick && redirect) |=> (bit_win[4:0] == 5'd0) && (bit_win[6:5] == 2'b10));

  a_r5_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r8_halted_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  a_r8_no_fetch_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !fetch_en);

endmodule

bind serial_issue_ctrl serial_issue_ctrl_sva u_sva (
  .clk      (clk),
  .rst      (rst),
  .fetch_en (fetch_en),
  .sys_tick (sys_tick),
  .imem_addr(imem_addr),
  .redirect (redirect),
  .halted   (halted),
  .bit_win  (bit_win),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr)
);

// File: tb/serial_issue_ctrl_bench.sv
`timescale 1ns/1ps
module serial_issue_ctrl_bench;

  localparam int DIV = 16;
  localparam int IBW = 16;
  localparam int DBW = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fetch_en, rd_en, alu_en, mem_rd, mem_wr, br_zero, redirect, wb_en, sys_tick, halted;
  logic [7:0] imem_addr, mem_addr;
  logic [15:0] imem_data;
  logic [1:0] rd_sel_x, rd_sel_y, wb_sel;
  logic [2:0] alu_op;
  logic [3:0] bit_idx;
  logic [6:0] bit_win;

  logic [15:0] imem [256];
  bit          zmap [256];

  always #2.5 clk = ~clk;
  assign imem_data = imem[imem_addr];

  serial_issue_ctrl #(.SYS_DIV(DIV), .INSTR_BITS(IBW), .DATA_BITS(DBW)) u_serial_issue_ctrl (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .imem_addr(imem_addr), .imem_data(imem_data),
    .rd_en(rd_en), .rd_sel_x(rd_sel_x), .rd_sel_y(rd_sel_y), .alu_en(alu_en), .alu_op(alu_op),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .br_zero(br_zero),
    .redirect(redirect), .wb_en(wb_en), .wb_sel(wb_sel), .sys_tick(sys_tick),
    .bit_idx(bit_idx), .bit_win(bit_win), .halted(halted)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  // ---------------- behavioural reference model ----------------
  typedef struct { int age; logic [15:0] w; int a; } rec_t;
  rec_t fl[$];
  int m_pc, m_slot, m_ticks;
  bit m_stop, m_halt;

  function automatic logic [15:0] enc_r(int f, int d, int x, int y);
    return {3'd1, 3'(f), 2'(d), 2'(x), 2'(y), 4'd0};
  endfunction
  function automatic logic [15:0] enc_m(int op, int r, int a);
    return {3'(op), 3'd0, 2'(r), 8'(a)};
  endfunction

  function automatic int opc(logic [15:0] w); return int'(w[15:13]); endfunction
  function automatic bit legal_r(logic [15:0] w); return opc(w) == 1 && w[12:10] != 3'd7; endfunction

  function automatic int find_age(int g);
    foreach (fl[i]) if (fl[i].age == g) return i;
    return -1;
  endfunction

  function automatic bit model_taken();
    int k;
    k = find_age(5);
    if (k < 0) return 0;
    case (opc(fl[k].w))
      6: return 1;
      4: return br_zero;
      5: return !br_zero;
      default: return 0;
    endcase
  endfunction

  task automatic model_clear();
    fl.delete();
    m_pc = 0; m_slot = 0; m_ticks = 0; m_stop = 0; m_halt = 0;
  endtask

  task automatic drive_zero();
    int k;
    k = find_age(5);
    br_zero = (k >= 0) ? zmap[fl[k].a] : (m_slot % 3 == 0);
  endtask

  task automatic compare();
    int k;
    bit tk, is_tick;
    logic [15:0] w;
    logic e_rd, e_alu, e_mr, e_mw, e_wb;
    logic [1:0] e_x, e_y, e_ws;
    logic [2:0] e_op;
    logic [7:0] e_ma;
    logic [6:0] e_win;
    tk = model_taken();
    is_tick = (m_slot == DIV - 1);
    e_rd = 0; e_x = 0; e_y = 0; e_alu = 0; e_op = 0; e_mr = 0; e_mw = 0; e_ma = 0;
    e_wb = 0; e_ws = 0; e_win = 0;
    k = find_age(3);
    if (k >= 0) begin
      w = fl[k].w;
      if (legal_r(w)) begin e_rd = 1; e_x = w[7:6]; e_y = w[5:4]; end
      else if (opc(w) == 3 || opc(w) == 4 || opc(w) == 5) begin e_rd = 1; e_x = w[9:8]; end
    end
    k = find_age(4);
    if (k >= 0 && legal_r(fl[k].w)) begin e_alu = 1; e_op = fl[k].w[12:10]; end
    k = find_age(5);
    if (k >= 0) begin
      w = fl[k].w;
      e_mr = (opc(w) == 2);
      e_mw = (opc(w) == 3);
      if (e_mr || e_mw) e_ma = w[7:0];
    end
    k = find_age(6);
    if (k >= 0 && (legal_r(fl[k].w) || opc(fl[k].w) == 2)) begin e_wb = 1; e_ws = fl[k].w[9:8]; end
    foreach (fl[i]) if (m_slot < ((fl[i].age <= 3) ? IBW : DBW)) e_win[fl[i].age] = 1'b1;

    chk("R10", "sys_tick", sys_tick, is_tick);
    chk("R10", "bit_idx", bit_idx, m_slot);
    chk("R2", "fetch_en", fetch_en, is_tick && (m_ticks % 2 == 0) && !m_stop && !tk);
    chk("R11 R6", "imem_addr", imem_addr, m_pc);
    chk("R3 R10", "bit_win", bit_win, e_win);
    chk("R4 R5 R6", "read", {rd_en, rd_sel_x, rd_sel_y}, {e_rd, e_x, e_y});
    chk("R4", "alu", {alu_en, alu_op}, {e_alu, e_op});
    chk("R5", "mem", {mem_rd, mem_wr, mem_addr}, {e_mr, e_mw, e_ma});
    chk("R6 R7 R9", "redirect", redirect, tk);
    chk("R4 R5", "writeback", {wb_en, wb_sel}, {e_wb, e_ws});
    chk("R8", "halted", halted, m_halt);
  endtask

  task automatic advance();
    rec_t nq[$];
    rec_t r;
    bit tk;
    int k;
    if (m_slot == DIV - 1) begin
      tk = model_taken();
      k = find_age(5);
      k = (k >= 0) ? int'(fl[k].w[7:0]) : 0;
      foreach (fl[i]) if (fl[i].age == 6 && opc(fl[i].w) == 7) m_halt = 1;
      foreach (fl[i]) begin
        r = fl[i];
        if (!(tk && r.age < 5) && r.age < 6) begin
          r.age++;
          nq.push_back(r);
        end
      end
      fl = nq;
      if ((m_ticks % 2 == 0) && !m_stop && !tk) begin
        r.age = 0; r.w = imem[m_pc]; r.a = m_pc;
        fl.push_back(r);
        if (opc(r.w) == 7) m_stop = 1;
        m_pc = (m_pc + 1) % 256;
      end
      if (tk) begin m_pc = k; m_stop = 0; end
      m_ticks++;
    end
    m_slot = (m_slot + 1) % DIV;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      drive_zero();
      #1;
      compare();
      advance();
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "fetch addr in reset", imem_addr, 8'd0);
    chk("R1", "stages in reset", bit_win, 7'd0);
    chk("R1", "strobes in reset", {rd_en, alu_en, mem_rd, mem_wr, wb_en, redirect, fetch_en}, 7'd0);
    chk("R1", "halted in reset", halted, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    br_zero = 1'b0;
    for (int a = 0; a < 256; a++) begin imem[a] = 16'h0000; zmap[a] = 0; end
    // R4: every ALU function, then an undefined one; R8: a no-op
    for (int f = 0; f < 7; f++) imem[f] = enc_r(f, (f + 1) % 4, f % 4, (f + 2) % 4);
    imem[7]  = enc_r(7, 3, 1, 2);
    imem[8]  = enc_m(0, 0, 0);
    imem[9]  = enc_m(2, 2, 8'h33);              // R5 load
    imem[10] = enc_m(3, 1, 8'h44);              // R5 store
    imem[11] = enc_m(4, 0, 8'h20); zmap[11] = 0; // R6 zero-test, not taken
    imem[12] = enc_m(5, 1, 8'h20); zmap[12] = 1; // R6 nonzero-test, not taken
    imem[13] = enc_m(4, 2, 8'h20); zmap[13] = 1; // R6 zero-test, taken
    imem[14] = enc_m(7, 0, 0);                  // R9 halt cancelled by flush
    imem[8'h20] = enc_m(5, 3, 8'h30); zmap[8'h20] = 0; // R6 nonzero-test, taken
    imem[8'h21] = enc_r(0, 1, 1, 1);
    imem[8'h30] = enc_m(6, 0, 8'hFE);           // R7 jump
    imem[8'hFE] = enc_m(3, 2, 8'h9A);
    imem[8'hFF] = enc_m(6, 0, 8'h40);           // R11 wrap to 0 then flushed
    imem[8'h40] = enc_m(2, 3, 8'h55);
    imem[8'h41] = enc_m(7, 0, 0);               // R8 final halt

    @(negedge clk);
    do_reset();
    // R1: first fetch from address 0 on the first tick
    #1;
    chk("R1", "fetch addr after reset", imem_addr, 8'd0);
    chk("R1", "halted after reset", halted, 1'b0);
    run_cycles(2000);
    chk("R8", "halted at end of program", halted, 1'b1);
    chk("R8", "fetch after halt", fetch_en, 1'b0);
    chk("R8", "stages drained", bit_win, 7'd0);

    // reset while the pipeline is busy
    do_reset();
    run_cycles(300);
    do_reset();
    run_cycles(200);
    finish_run();
  end

endmodule